// File: doc/BRIEF.md
# Reversible LFSR Address Stepper

This block produces the address stream for a memory self-test engine. It uses a shift register with linear feedback instead of a binary counter. On every enabled clock it moves to the next address in the chosen direction. A correction term sends the register through the all-zero state, so each of the 2^WIDTH addresses appears exactly once per pass. Going forward, the feedback comes from the characteristic polynomial. Going backward, each stage takes its other neighbour and the feedback comes from the reciprocal polynomial. As a result, the backward walk visits the forward walk's addresses in exactly the opposite order, which is the ordering that march algorithms need.

A march sequencer drives the enable and direction inputs. It watches the end-of-pass flag to decide when a march element is complete, and the address goes through the self-test address mux to the row decoder. The polynomial and width are parameters. The default is a 3-stage register with G(x) = x^3 + x + 1.

Top module: `lfsr_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the address to 0. Right after reset, with up = 1, the end-of-pass flag is 0.
- R2: With en = 1 and up = 1, the address advances each edge through the decimal sequence 0, 1, 3, 7, 6, 5, 2, 4 and then wraps to 0. Here addr[0] is the first stage.
- R3: With en = 1 and up = 0, the address advances each edge through 0, 4, 2, 5, 6, 7, 3, 1 and then wraps to 0, which is the R2 order reversed.
- R4: A run of 2^WIDTH consecutive enabled steps in one direction visits every address value exactly once.
- R5: With en = 0 the address keeps its value, whatever the level of up.
- R6: When the direction changes at any state, the next enabled step moves to that state's neighbour in the new direction.
- R7: With up = 1, the end-of-pass flag is 1 exactly when the address is the last one of a forward pass (value 4, only the top bit set) and 0 otherwise.
- R8: With up = 0, the end-of-pass flag is 1 exactly when the address is the last one of a backward pass (value 1, only bit 0 set) and 0 otherwise.
- R9: A forward step shifts addr[i-1] into addr[i]. A backward step shifts addr[i+1] into addr[i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance one address on this edge |
| up | input | 1 | 1 = forward walk, 0 = backward walk |
| addr | output | WIDTH | Current address, bit 0 is the first stage |
| last | output | 1 | Current address ends a pass in the selected direction |

## Verification
The properties assume that en and up are stable around each rising edge and that they are never X. This matters most for the combinational end-of-pass flag, which follows up within the same cycle. The bench changes every input only on the falling edge and never leaves one undriven. Reset is applied only as a full synchronous cycle. Reversals are placed both at the wrap point and in the middle of a pass, so that the shift properties are exercised in each direction and starting from zero.

// File: rtl/lfsr_addr_pkg.sv
package lfsr_addr_pkg;

    // Walk direction as seen by the march sequencer.
    typedef enum logic {
        WALK_DOWN = 1'b0,
        WALK_UP   = 1'b1
    } walk_dir_e;

    // Per-cycle control sampled at the clock edge.
    typedef struct packed {
        logic      advance;
        walk_dir_e dir;
    } step_ctrl_t;

    // Default characteristic polynomial: coefficients of x^0..x^(W-1),
    // with x^W implied. 3'b011 means x^3 + x + 1.
    localparam int unsigned DEF_WIDTH = 3;
    localparam logic [DEF_WIDTH-1:0] DEF_POLY = 3'b011;

    // Build step control from the raw pins.
    function automatic step_ctrl_t make_ctrl(input logic en, input logic up);
        step_ctrl_t c;
        c.advance = en;
        c.dir     = up ? WALK_UP : WALK_DOWN;
        return c;
    endfunction

endpackage

// File: rtl/lfsr_fb_fwd.sv
// Forward feedback into stage 0: XOR of the tapped stages, corrected so
// that the register passes through all-zero.
module lfsr_fb_fwd #(
    parameter int unsigned     WIDTH = 3,
    parameter logic [WIDTH-1:0] POLY = 3'b011
) (
    input  logic [WIDTH-1:0] state,
    output logic             fb
);
    logic [WIDTH-1:0] tap_mask;
    logic             low_zero;

    // Coefficient k (1..W-1) taps stage k-1; the x^W term taps the last stage.
    for (genvar k = 1; k < WIDTH; k++) begin : g_tap
        assign tap_mask[k-1] = POLY[k];
    end
    assign tap_mask[WIDTH-1] = 1'b1;

    // All stages but the last are zero: either the lone-top-bit state
    // or all-zero, where the correction swaps the two successors.
    assign low_zero = ~|state[WIDTH-2:0];
    assign fb       = (^(state & tap_mask)) ^ low_zero;
endmodule

// File: rtl/lfsr_fb_rev.sv
// Reverse feedback into the last stage: undoes one forward step, which
// amounts to the reciprocal polynomial, with the mirrored zero correction.
module lfsr_fb_rev #(
    parameter int unsigned     WIDTH = 3,
    parameter logic [WIDTH-1:0] POLY = 3'b011
) (
    input  logic [WIDTH-1:0] state,
    output logic             fb
);
    logic [WIDTH-1:0] tap_mask;
    logic             high_zero;

    // Stage 0 always contributes. Stage k (1..W-1) contributes when
    // coefficient k is set.
    assign tap_mask[0] = 1'b1;
    for (genvar k = 1; k < WIDTH; k++) begin : g_tap
        assign tap_mask[k] = POLY[k];
    end

    assign high_zero = ~|state[WIDTH-1:1];
    assign fb        = (^(state & tap_mask)) ^ high_zero;
endmodule

// File: rtl/lfsr_stage.sv
// One register stage with its 2:1 direction mux and hold.
module lfsr_stage
    import lfsr_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  step_ctrl_t ctrl,
    input  logic       src_up,
    input  logic       src_dn,
    output logic       q
);
    logic d_sel;

    always_comb begin
        d_sel = (ctrl.dir == WALK_UP) ? src_up : src_dn;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (ctrl.advance) begin
            q <= d_sel;
        end
    end
endmodule

// File: rtl/lfsr_addr_gen.sv
module lfsr_addr_gen
    import lfsr_addr_pkg::*;
#(
    parameter int unsigned      WIDTH = DEF_WIDTH,
    parameter logic [WIDTH-1:0] POLY  = DEF_POLY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             up,
    output logic [WIDTH-1:0] addr,
    output logic             last
);
    localparam logic [WIDTH-1:0] END_UP = WIDTH'(1) << (WIDTH - 1);
    localparam logic [WIDTH-1:0] END_DN = WIDTH'(1);

    step_ctrl_t       ctrl;
    logic [WIDTH-1:0] state;
    logic [WIDTH-1:0] src_up;
    logic [WIDTH-1:0] src_dn;
    logic             fb_fwd;
    logic             fb_rev;

    assign ctrl = make_ctrl(en, up);

    lfsr_fb_fwd #(.WIDTH(WIDTH), .POLY(POLY)) u_fb_fwd (
        .state (state),
        .fb    (fb_fwd)
    );

    lfsr_fb_rev #(.WIDTH(WIDTH), .POLY(POLY)) u_fb_rev (
        .state (state),
        .fb    (fb_rev)
    );

    // Stage i takes its lower neighbour going up and its upper neighbour
    // going down; the end stages take the feedback bits instead.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign src_up[i] = fb_fwd;
        end else begin : g_mid_up
            assign src_up[i] = state[i-1];
        end
        if (i == WIDTH - 1) begin : g_final
            assign src_dn[i] = fb_rev;
        end else begin : g_mid_dn
            assign src_dn[i] = state[i+1];
        end

        lfsr_stage u_stage (
            .clk    (clk),
            .rst    (rst),
            .ctrl   (ctrl),
            .src_up (src_up[i]),
            .src_dn (src_dn[i]),
            .q      (state[i])
        );
    end

    assign addr = state;
    assign last = (ctrl.dir == WALK_UP) ? (state == END_UP) : (state == END_DN);
endmodule

// File: rtl/lfsr_addr_gen_chk.sv
module lfsr_addr_gen_chk #(
    parameter int unsigned WIDTH = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             up,
    input logic [WIDTH-1:0] addr,
    input logic             last
);
    // R1: reset leaves the address at zero.
    p_rst_zero_r1: assert property (@(posedge clk) rst |=> addr == '0);

    // R2: a forward step from zero lands on 1.
    p_up_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (en && up && addr == '0) |=> addr == WIDTH'(1));

    // R3: a backward step from zero lands on the top-bit value.
    p_dn_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !up && addr == '0) |=> addr == (WIDTH'(1) << (WIDTH - 1)));

    // R5: the address holds when not enabled.
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(addr));

    // R9: forward step shifts towards the top.
    p_up_shift_r9: assert property (@(posedge clk) disable iff (rst)
        (en && up) |=> addr[WIDTH-1:1] == $past(addr[WIDTH-2:0]));

    // R9: backward step shifts towards bit 0.
    p_dn_shift_r9: assert property (@(posedge clk) disable iff (rst)
        (en && !up) |=> addr[WIDTH-2:0] == $past(addr[WIDTH-1:1]));

    // R7/R8: the flag only marks a single-bit address.
    p_last_single_r7: assert property (@(posedge clk) disable iff (rst)
        last |-> $countones(addr) == 1);
endmodule

bind lfsr_addr_gen lfsr_addr_gen_chk #(.WIDTH(WIDTH)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .up   (up),
    .addr (addr),
    .last (last)
);

// File: tb/tb_lfsr_addr_gen.sv
module tb_lfsr_addr_gen;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic         up  = 1'b1;
    logic [W-1:0] addr;
    logic         last;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    lfsr_addr_gen dut (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .up   (up),
        .addr (addr),
        .last (last)
    );

    // Row: {en, up, expected addr, expected last} after one edge.
    localparam int NV = 23;
    localparam logic [5:0] VEC [NV] = '{
        {1'b1, 1'b1, 3'd1, 1'b0},  // R2 forward pass from reset
        {1'b1, 1'b1, 3'd3, 1'b0},
        {1'b1, 1'b1, 3'd7, 1'b0},
        {1'b1, 1'b1, 3'd6, 1'b0},
        {1'b1, 1'b1, 3'd5, 1'b0},
        {1'b1, 1'b1, 3'd2, 1'b0},
        {1'b1, 1'b1, 3'd4, 1'b1},  // R7 end of forward pass
        {1'b1, 1'b1, 3'd0, 1'b0},
        {1'b1, 1'b1, 3'd1, 1'b0},
        {1'b0, 1'b1, 3'd1, 1'b0},  // R5 hold
        {1'b1, 1'b0, 3'd0, 1'b0},  // R6 reverse at 1
        {1'b1, 1'b0, 3'd4, 1'b0},  // R3 backward pass
        {1'b1, 1'b0, 3'd2, 1'b0},
        {1'b1, 1'b0, 3'd5, 1'b0},
        {1'b1, 1'b0, 3'd6, 1'b0},
        {1'b1, 1'b0, 3'd7, 1'b0},
        {1'b1, 1'b0, 3'd3, 1'b0},
        {1'b1, 1'b0, 3'd1, 1'b1},  // R8 end of backward pass
        {1'b1, 1'b0, 3'd0, 1'b0},
        {1'b1, 1'b0, 3'd4, 1'b0},
        {1'b0, 1'b0, 3'd4, 1'b0},  // R5 hold, R7 flag off when walking down
        {1'b1, 1'b1, 3'd0, 1'b0},  // R6 reverse at 4
        {1'b1, 1'b1, 3'd1, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic u);
        @(negedge clk);
        en = e;
        up = u;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        string tag;
        bit    seen [8];

        // R1 reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 addr", int'(addr), 0);
        check("R1 last", int'(last), 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5], VEC[i][4]);
            tag = !VEC[i][5] ? "R5" : (VEC[i][4] ? "R2" : "R3");
            check(tag, int'(addr), int'(VEC[i][3:1]));
            check(VEC[i][4] ? "R7 last" : "R8 last", int'(last), int'(VEC[i][0]));
        end

        // R5: en low while up toggles, state must not move
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        check("R5 toggle", int'(addr), 1);

        // R4 forward: a full pass visits every value once
        for (int k = 0; k < 8; k++) seen[k] = 1'b0;
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1'b1);
            check("R4 up unique", int'(seen[addr]), 0);
            seen[addr] = 1'b1;
        end
        // R4 backward
        for (int k = 0; k < 8; k++) seen[k] = 1'b0;
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1'b0);
            check("R4 down unique", int'(seen[addr]), 0);
            seen[addr] = 1'b1;
        end
        check("R4 end", int'(addr), 1);

        // R6 mid-pass reversal: 1 -> 3 -> 7 forward, then back to 3
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        check("R6 pre", int'(addr), 7);
        step(1'b1, 1'b0);
        check("R6 back", int'(addr), 3);
        check("R9 down shift", int'(addr[1:0]), 3);
        step(1'b1, 1'b1);
        check("R6 fwd again", int'(addr), 7);

        // R8: at 1 the flag follows the direction pin
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        check("R8 at 1", int'(last), 1);
        @(negedge clk);
        up = 1'b1;
        #1;
        check("R7 at 1 going up", int'(last), 0);

        // R1 reset in mid-pass
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        en  = 1'b0;
        #1;
        check("R1 mid reset", int'(addr), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule